// File: doc/BRIEF.md
# Graphics Engine Interrupt Register Bank

This block gathers the interrupt sources of a graphics engine and presents them to a host through a small word-addressed register port. There are three sources. The render frame finished pulse and the binner flush finished pulse are one-cycle events that latch into a pending-status register. The binner out-of-memory condition is a level: once raised, it stays raised until the host supplies fresh overflow memory. The host acknowledges a pending bit by writing 1 to it.

Each source has an enable bit. Two separate addresses change the enable mask. A 1 written to the set address turns bits on, and a 1 written to the clear address turns bits off. Both addresses read back the same mask. The single interrupt line to the host is the registered OR of the pending bits that are enabled. Two storage registers hold the base and the byte count of the overflow memory handed to the binner. A write to the byte-count register tells the block that the memory has been refilled.

Top module: `gpu_irq_regbank`

## Requirements
- R1: After reset, the pending status, the enable mask, both overflow registers, the read data and `irq` are all zero.
- R2: A write to byte offset 0x00 clears every pending bit written as 1. Pending bits written as 0 keep their value.
- R3: Status bit 0 is render frame done, bit 1 is binner flush done and bit 2 is binner out of memory. A one-cycle pulse on `evt_frame_done` or `evt_flush_done` sets its bit at the next clock edge, and the bit holds until it is acknowledged.
- R4: If an event pulse arrives in the same cycle as a write-1 acknowledge of its own bit, the bit stays set.
- R5: A write to offset 0x04 sets every enable bit written as 1. Bits written as 0 are left alone. With no write to 0x04 or 0x08, the mask does not change.
- R6: A write to offset 0x08 clears every enable bit written as 1. Bits written as 0 are left alone.
- R7: A read of 0x04 and a read of 0x08 both return the current enable mask. Bits 31..3 of the status and mask registers read 0, and unmapped offsets read 0.
- R8: A pulse on `bin_oom` raises an out-of-memory condition that sets status bit 2 at the next edge. While the condition remains, a write-1 acknowledge of bit 2 has no effect.
- R9: Offset 0x0C (overflow base) and offset 0x10 (overflow byte count) store the full written word, drive it on `pool_base` and `pool_bytes`, and read it back. A write to 0x10 removes the out-of-memory condition, after which an acknowledge clears bit 2.
- R10: `irq` is high one cycle after any status bit and its enable bit are both set, and low one cycle after no such pair exists.
- R11: A read issued in cycle k places, after the edge ending cycle k, the register value as it was during cycle k on `bus_rdata`. `bus_rdata` holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| evt_frame_done | input | 1 | One-cycle render frame finished pulse |
| evt_flush_done | input | 1 | One-cycle binner flush finished pulse |
| bin_oom | input | 1 | Binner out-of-memory indication |
| pool_base | output | DATA_W | Stored overflow memory base |
| pool_bytes | output | DATA_W | Stored overflow memory byte count |
| irq | output | 1 | Interrupt request to the host |

## Verification
The assertions assume an access is a single-cycle request with a word-aligned address, and that the bus does not write the enable-set and enable-clear addresses in the same cycle. Since each cycle carries only one access, this always holds. They also assume the event inputs are clean single-cycle pulses that are low during reset. The bench drives every input at the falling edge, issues at most one access per cycle, pulses the events for exactly one cycle, and keeps them low while reset is asserted.

// File: rtl/gpu_irq_pkg.sv
package gpu_irq_pkg;
  localparam int NSRC      = 3;
  localparam int SRC_FRAME = 0;
  localparam int SRC_FLUSH = 1;
  localparam int SRC_OOM   = 2;

  // Word index of each register (byte offset >> 2)
  typedef enum logic [2:0] {
    RIDX_STAT  = 3'd0,
    RIDX_ENSET = 3'd1,
    RIDX_ENCLR = 3'd2,
    RIDX_PBASE = 3'd3,
    RIDX_PSIZE = 3'd4
  } reg_idx_e;

  typedef struct packed {
    logic stat;
    logic en_set;
    logic en_clr;
    logic pbase;
    logic psize;
  } wr_strb_t;
endpackage

// File: rtl/gpu_irq_status.sv
module gpu_irq_status #(
  parameter int NSRC = 3,
  parameter int OOM_BIT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_vec,
  input  logic            oom_raise,
  input  logic            oom_refill,
  input  logic            ack_wr,
  input  logic [NSRC-1:0] ack_mask,
  output logic [NSRC-1:0] stat_q
);
  logic            oom_hold_q, oom_hold_d, oom_hold_ce;
  logic [NSRC-1:0] cond_vec;
  logic [NSRC-1:0] stat_d;
  logic [NSRC-1:0] stat_ce;

  // Out-of-memory condition: raised by the binner, dropped on refill
  always_comb begin
    oom_hold_ce = oom_raise | oom_refill;
    oom_hold_d  = oom_raise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           oom_hold_q <= 1'b0;
    else if (oom_hold_ce) oom_hold_q <= oom_hold_d;
  end

  always_comb begin
    cond_vec          = evt_vec;
    cond_vec[OOM_BIT] = evt_vec[OOM_BIT] | oom_raise | oom_hold_q;
  end

  genvar b;
  generate
    for (b = 0; b < NSRC; b++) begin : g_bit
      always_comb begin
        stat_ce[b] = cond_vec[b] | (ack_wr & ack_mask[b]);
        stat_d[b]  = cond_vec[b];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          stat_q[b] <= 1'b0;
        else if (stat_ce[b]) stat_q[b] <= stat_d[b];
      end
    end
  endgenerate
endmodule

// File: rtl/gpu_irq_enable.sv
module gpu_irq_enable #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_wr,
  input  logic            clr_wr,
  input  logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] en_q
);
  logic [NSRC-1:0] en_d;
  logic            en_ce;

  always_comb begin
    en_ce = set_wr | clr_wr;
    en_d  = en_q;
    if (set_wr) en_d = en_d | mask;
    if (clr_wr) en_d = en_d & ~mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end
endmodule

// File: rtl/gpu_irq_pool.sv
module gpu_irq_pool #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr,
  input  logic              size_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] base_q,
  output logic [DATA_W-1:0] size_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_wr) base_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       size_q <= '0;
    else if (size_wr) size_q <= wdata;
  end
endmodule

// File: rtl/gpu_irq_regbank.sv
module gpu_irq_regbank #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              evt_frame_done,
  input  logic              evt_flush_done,
  input  logic              bin_oom,
  output logic [DATA_W-1:0] pool_base,
  output logic [DATA_W-1:0] pool_bytes,
  output logic              irq
);
  import gpu_irq_pkg::*;

  localparam int IDX_W = ADDR_W - 2;

  logic              rst_meta_q, rst_sync_n;
  logic [IDX_W-1:0]  idx;
  wr_strb_t          wstrb;
  logic              rd_req;
  logic [NSRC-1:0]   evt_vec;
  logic [NSRC-1:0]   stat_vec;
  logic [NSRC-1:0]   en_vec;
  logic [DATA_W-1:0] rd_mux;
  logic              irq_d;

  // Reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Address decode
  always_comb begin
    idx          = bus_addr[ADDR_W-1:2];
    rd_req       = bus_sel & ~bus_wr;
    wstrb.stat   = bus_sel & bus_wr & (idx == IDX_W'(RIDX_STAT));
    wstrb.en_set = bus_sel & bus_wr & (idx == IDX_W'(RIDX_ENSET));
    wstrb.en_clr = bus_sel & bus_wr & (idx == IDX_W'(RIDX_ENCLR));
    wstrb.pbase  = bus_sel & bus_wr & (idx == IDX_W'(RIDX_PBASE));
    wstrb.psize  = bus_sel & bus_wr & (idx == IDX_W'(RIDX_PSIZE));
  end

  always_comb begin
    evt_vec            = '0;
    evt_vec[SRC_FRAME] = evt_frame_done;
    evt_vec[SRC_FLUSH] = evt_flush_done;
  end

  gpu_irq_status #(.NSRC(NSRC), .OOM_BIT(SRC_OOM)) u_status (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .evt_vec    (evt_vec),
    .oom_raise  (bin_oom),
    .oom_refill (wstrb.psize),
    .ack_wr     (wstrb.stat),
    .ack_mask   (bus_wdata[NSRC-1:0]),
    .stat_q     (stat_vec)
  );

  gpu_irq_enable #(.NSRC(NSRC)) u_enable (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_wr (wstrb.en_set),
    .clr_wr (wstrb.en_clr),
    .mask   (bus_wdata[NSRC-1:0]),
    .en_q   (en_vec)
  );

  gpu_irq_pool #(.DATA_W(DATA_W)) u_pool (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .base_wr (wstrb.pbase),
    .size_wr (wstrb.psize),
    .wdata   (bus_wdata),
    .base_q  (pool_base),
    .size_q  (pool_bytes)
  );

  // Read path
  always_comb begin
    rd_mux = '0;
    unique case (idx)
      IDX_W'(RIDX_STAT):  rd_mux[NSRC-1:0] = stat_vec;
      IDX_W'(RIDX_ENSET): rd_mux[NSRC-1:0] = en_vec;
      IDX_W'(RIDX_ENCLR): rd_mux[NSRC-1:0] = en_vec;
      IDX_W'(RIDX_PBASE): rd_mux = pool_base;
      IDX_W'(RIDX_PSIZE): rd_mux = pool_bytes;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  bus_rdata <= '0;
    else if (rd_req)  bus_rdata <= rd_mux;
  end

  // Interrupt output
  always_comb irq_d = |(stat_vec & en_vec);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq <= 1'b0;
    else             irq <= irq_d;
  end
endmodule

// File: rtl/gpu_irq_regbank_chk.sv
module gpu_irq_regbank_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic                        clk,
  input logic                        rst_sync_n,
  input logic                        bus_sel,
  input logic                        bus_wr,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [DATA_W-1:0]           bus_wdata,
  input logic                        evt_frame_done,
  input logic                        bin_oom,
  input logic [gpu_irq_pkg::NSRC-1:0] stat_vec,
  input logic [gpu_irq_pkg::NSRC-1:0] en_vec,
  input logic [DATA_W-1:0]           pool_base,
  input logic [DATA_W-1:0]           pool_bytes,
  input logic                        irq
);
  import gpu_irq_pkg::*;

  logic            w_stat, w_set, w_clr, w_pool;
  logic [NSRC-1:0] wmask;

  always_comb begin
    wmask  = bus_wdata[NSRC-1:0];
    w_stat = bus_sel & bus_wr & (bus_addr == ADDR_W'(8'h00));
    w_set  = bus_sel & bus_wr & (bus_addr == ADDR_W'(8'h04));
    w_clr  = bus_sel & bus_wr & (bus_addr == ADDR_W'(8'h08));
    w_pool = bus_sel & bus_wr & ((bus_addr == ADDR_W'(8'h0C)) | (bus_addr == ADDR_W'(8'h10)));
  end

  p_ack_clears_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (w_stat && wmask[SRC_FRAME] && !evt_frame_done) |=> !stat_vec[SRC_FRAME]);

  p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    evt_frame_done |=> stat_vec[SRC_FRAME]);

  p_enable_set_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    w_set |=> ((en_vec & $past(wmask)) == $past(wmask)));

  p_enable_hold_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(w_set || w_clr) |=> $stable(en_vec));

  p_enable_clear_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    w_clr |=> ((en_vec & $past(wmask)) == '0));

  p_oom_raised_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bin_oom |=> stat_vec[SRC_OOM]);

  p_pool_stable_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !w_pool |=> ($stable(pool_base) && $stable(pool_bytes)));

  p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|(stat_vec & en_vec)) |=> irq);

  p_irq_fall_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(|(stat_vec & en_vec)) |=> !irq);
endmodule

bind gpu_irq_regbank gpu_irq_regbank_chk u_chk (
  .clk            (clk),
  .rst_sync_n     (rst_sync_n),
  .bus_sel        (bus_sel),
  .bus_wr         (bus_wr),
  .bus_addr       (bus_addr),
  .bus_wdata      (bus_wdata),
  .evt_frame_done (evt_frame_done),
  .bin_oom        (bin_oom),
  .stat_vec       (stat_vec),
  .en_vec         (en_vec),
  .pool_base      (pool_base),
  .pool_bytes     (pool_bytes),
  .irq            (irq)
);

// File: tb/gpu_irq_regbank_tb.sv
`timescale 1ns/1ps
module gpu_irq_regbank_tb;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int NV     = 19;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_sel, bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              evt_frame_done, evt_flush_done, bin_oom;
  logic [DATA_W-1:0] pool_base, pool_bytes;
  logic              irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  gpu_irq_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_frame_done(evt_frame_done), .evt_flush_done(evt_flush_done),
    .bin_oom(bin_oom), .pool_base(pool_base), .pool_bytes(pool_bytes),
    .irq(irq)
  );

  // Vector: {wr, waddr[4:0], wdata[7:0], ev{oom,flush,frame}, raddr[4:0], exp[7:0]}
  localparam logic [29:0] VEC [NV] = '{
    {1'b0, 5'h00, 8'h00, 3'b000, 5'h00, 8'h00}, // 0  R1 idle status
    {1'b0, 5'h00, 8'h00, 3'b001, 5'h00, 8'h01}, // 1  R3 frame done
    {1'b0, 5'h00, 8'h00, 3'b010, 5'h00, 8'h03}, // 2  R3 flush done
    {1'b1, 5'h00, 8'h02, 3'b000, 5'h00, 8'h01}, // 3  R2 ack bit1
    {1'b1, 5'h00, 8'h00, 3'b000, 5'h00, 8'h01}, // 4  R2 zero write
    {1'b1, 5'h04, 8'h05, 3'b000, 5'h04, 8'h05}, // 5  R5 set
    {1'b1, 5'h04, 8'h00, 3'b000, 5'h08, 8'h05}, // 6  R5 zero set, R7 alias
    {1'b1, 5'h08, 8'h01, 3'b000, 5'h04, 8'h04}, // 7  R6 clear
    {1'b1, 5'h08, 8'h00, 3'b000, 5'h08, 8'h04}, // 8  R6 zero clear
    {1'b1, 5'h04, 8'hFF, 3'b000, 5'h04, 8'h07}, // 9  R7 unused bits
    {1'b1, 5'h00, 8'h01, 3'b001, 5'h00, 8'h01}, // 10 R4 event wins
    {1'b1, 5'h00, 8'hFF, 3'b000, 5'h00, 8'h00}, // 11 R2 ack all
    {1'b0, 5'h00, 8'h00, 3'b100, 5'h00, 8'h04}, // 12 R8 oom raised
    {1'b1, 5'h00, 8'h04, 3'b000, 5'h00, 8'h04}, // 13 R8 ack ignored
    {1'b1, 5'h0C, 8'hA5, 3'b000, 5'h0C, 8'hA5}, // 14 R9 base
    {1'b1, 5'h00, 8'h04, 3'b000, 5'h00, 8'h04}, // 15 R8 still held
    {1'b1, 5'h10, 8'h3C, 3'b000, 5'h10, 8'h3C}, // 16 R9 size refill
    {1'b1, 5'h00, 8'h04, 3'b000, 5'h00, 8'h00}, // 17 R9 ack now clears
    {1'b0, 5'h00, 8'h00, 3'b000, 5'h14, 8'h00}  // 18 R7 unmapped
  };
  localparam int VREQ [NV] = '{1,3,3,2,2,5,5,6,6,7,4,2,8,8,9,8,9,9,7};

  task automatic chk(input string req, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    evt_frame_done = 1'b0; evt_flush_done = 1'b0; bin_oom = 1'b0;
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    #1;
    chk("R1 rdata in reset", bus_rdata, '0);
    chk("R1 irq in reset", {31'b0, irq}, '0);
    chk("R1 pool in reset", pool_base | pool_bytes, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      v = VEC[i];
      bus_sel = v[29]; bus_wr = v[29]; bus_addr = v[28:24];
      bus_wdata = {24'b0, v[23:16]};
      {bin_oom, evt_flush_done, evt_frame_done} = v[15:13];
      @(negedge clk);
      idle_inputs();
      bus_sel = 1'b1; bus_addr = v[12:8];
      @(negedge clk);
      idle_inputs();
      chk($sformatf("R%0d vector %0d", VREQ[i], i), bus_rdata, {24'b0, v[7:0]});
    end

    // R9: stored words on the outputs
    chk("R9 pool_base", pool_base, 32'hA5);
    chk("R9 pool_bytes", pool_bytes, 32'h3C);

    // R10: enable mask is 7, status is 0
    @(negedge clk);
    evt_flush_done = 1'b1;
    @(negedge clk);
    evt_flush_done = 1'b0;
    chk("R10 irq one cycle late", {31'b0, irq}, '0);
    @(negedge clk);
    chk("R10 irq raised", {31'b0, irq}, 32'd1);
    bus_write(5'h08, 32'h2);
    chk("R10 irq still high after disable edge", {31'b0, irq}, 32'd1);
    @(negedge clk);
    chk("R10 irq dropped", {31'b0, irq}, '0);

    // R11: read returns pre-event value, then holds
    evt_frame_done = 1'b1; bus_sel = 1'b1; bus_addr = 5'h00;
    @(negedge clk);
    idle_inputs();
    chk("R11 read shows old status", bus_rdata, 32'h2);
    repeat (2) @(negedge clk);
    chk("R11 rdata holds", bus_rdata, 32'h2);
    bus_sel = 1'b1; bus_addr = 5'h00;
    @(negedge clk);
    idle_inputs();
    chk("R11 new read", bus_rdata, 32'h3);

    // R1: reset in the middle of a run
    rst_n = 1'b0;
    #1;
    chk("R1 rdata cleared", bus_rdata, '0);
    chk("R1 pool cleared", pool_base | pool_bytes, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_sel = 1'b1; bus_addr = 5'h04;
    @(negedge clk);
    idle_inputs();
    chk("R1 enable after reset", bus_rdata, '0);
    bus_sel = 1'b1; bus_addr = 5'h00;
    @(negedge clk);
    idle_inputs();
    chk("R1 status after reset", bus_rdata, '0);

    finish_run();
  end
endmodule